// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block watches eight interrupt request lines and latches a request on the inactive-to-active edge of each line. The active level is programmable. It resolves the pending, unmasked requests in fixed or rotating priority. It drives one interrupt line toward a host and answers an acknowledge with an 8-bit vector. The vector comes either from a per-line vector memory or from one shared entry.

A host programs the block through a single byte-wide write port. A select input marks each byte as a command or as data. Commands set and clear single mask and request bits, clear in-service bits, load the mode, switch the enable, and preselect a target for the data bytes that follow. That target is either the auto-clear register or the vector memory at a chosen line. In polled mode the interrupt line stays quiet and the host reads a group flag from the status byte instead.

Two instances can serve sixteen lines. Their interrupt outputs are ORed together, and each instance is acknowledged separately.

Top module: `vpic_top`

## Requirements
- R1: After pin reset, or after a command byte of 0x00, the request, in-service and auto-clear registers are zero and the mask register is all ones. The mode bits and the enable are zero, no target is preselected, and the vector memory contents are kept.
- R2: A request bit is set at the first clock edge where its line is at the active level and was inactive at the previous edge. A line held active does not set the bit again after it is cleared. With active-low polarity a falling input is the active edge. Loading a new polarity does not by itself latch any request. A new edge takes precedence over a clear of the same bit in the same cycle.
- R3: For line n in bits 2..0, the commands work on single bits: 0x18+n sets mask bit n, 0x28+n clears mask bit n, 0x48+n clears request bit n, and 0x58+n sets request bit n.
- R4: irq_o is high exactly when arm=1, enable=1, polled=0, and at least one request bit is set whose mask bit is clear.
- R5: In fixed mode the lowest-numbered pending unmasked line wins.
- R6: In rotating mode, once line w has been acknowledged, the search order starts at line w+1 and wraps, so w becomes lowest priority. After reset the search starts at line 0.
- R7: On a one-cycle ack_i with a winner, the winner's request bit clears. Its in-service bit sets unless its auto-clear bit is 1. vec_valid_o is high for the one following cycle with the vector on vec_o. An ack_i with no winner produces no vec_valid_o.
- R8: With the common-vector mode bit set, every acknowledge returns vector memory entry 0. Otherwise it returns the winner's own entry.
- R9: Command 0xC0 preselects the auto-clear register, and later data bytes load it. Command 0xE0+n preselects vector entry n, and each later data byte writes one entry and moves to the next, wrapping. Data bytes with nothing preselected change nothing.
- R10: In polled mode irq_o stays low. status_o bit 7 is 1 whenever a request is pending and unmasked, and status_o reads {group flag, irq_o, enable, mode[4:0]}.
- R11: Command 0x70+n clears in-service bit n.
- R12: Command 0x80|m loads the mode bits m[4:0]: bit 0 rotating, bit 1 common vector, bit 2 polled, bit 3 active-low, bit 4 arm. Commands 0xA1 and 0xA0 set and clear the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_in | input | 8 | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_is_data | input | 1 | 1: the byte is data for the preselected target; 0: the byte is a command |
| wr_byte | input | 8 | Host write byte |
| ack_i | input | 1 | Acknowledge pulse |
| rd_sel | input | 2 | Register read select: 0 request, 1 mask, 2 in-service, 3 auto-clear |
| rd_data_o | output | 8 | Selected register contents |
| status_o | output | 8 | Group flag, interrupt, enable and mode bits |
| irq_o | output | 1 | Interrupt request to the host |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_valid_o | output | 1 | Pulses for one cycle when vec_o holds a new vector |

## Verification
The hardest situation to reach is a rotating-priority resolve where the fixed order would pick a different line. The bench gets there by acknowledging line 1 while lines 3 and 6 stay pending. It then sets request bit 0 by command, so line 0 is pending below the rotation pointer, and checks that lines 3, 6 and then 0 win in turn. Polarity changes are covered too: the inputs sit at the newly active level when active-low mode is loaded, which shows that the load itself latches nothing.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    // Host target for data bytes
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ACR  = 2'd1,
        SEL_VEC  = 2'd2
    } presel_e;

    // Mode byte layout, bit 4 down to bit 0
    typedef struct packed {
        logic arm;
        logic active_low;
        logic polled;
        logic common;
        logic rotate;
    } mode_t;

    // Command opcodes in bits 7..3, line number in bits 2..0
    localparam logic [4:0] OP_SET_IMR = 5'b00011;
    localparam logic [4:0] OP_CLR_IMR = 5'b00101;
    localparam logic [4:0] OP_CLR_IRR = 5'b01001;
    localparam logic [4:0] OP_SET_IRR = 5'b01011;
    localparam logic [4:0] OP_CLR_ISR = 5'b01110;
    localparam logic [4:0] OP_ENABLE  = 5'b10100;
    localparam logic [4:0] OP_SEL_ACR = 5'b11000;
    localparam logic [4:0] OP_SEL_VEC = 5'b11100;
endpackage

// File: rtl/vpic_edge.sv
module vpic_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         low_q,   // polarity now in force
    input  logic         low_d,   // polarity for the next cycle
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        rise   = (req ^ {N{low_q}}) & ~prev_q;
        // track the level under the next polarity so a polarity load is silent
        prev_d = req ^ {N{low_d}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/vpic_resolver.sv
module vpic_resolver #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] win
);
    always_comb begin
        int unsigned idx;
        found = 1'b0;
        win   = '0;
        // scan from far to near so the nearest hit to start is kept last
        for (int k = N - 1; k >= 0; k--) begin
            idx = (int'(start) + k) % N;
            if (pend[idx]) begin
                found = 1'b1;
                win   = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/vpic_vecmem.sv
module vpic_vecmem #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_in,
    input  logic          wr_en,
    input  logic          wr_is_data,
    input  logic [7:0]    wr_byte,
    input  logic          ack_i,
    input  logic [1:0]    rd_sel,
    output logic [N-1:0]  rd_data_o,
    output logic [7:0]    status_o,
    output logic          irq_o,
    output logic [VW-1:0] vec_o,
    output logic          vec_valid_o
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]  irr;
        logic [N-1:0]  imr;
        logic [N-1:0]  isr;
        logic [N-1:0]  acr;
        mode_t         mode;
        logic          en;
        presel_e       sel;
        logic [IW-1:0] vptr;
        logic [IW-1:0] last;
        logic [VW-1:0] vec;
        logic          vval;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0]  pending, rise;
    logic [IW-1:0] start, win, line, rd_addr;
    logic          found, is_cmd, do_reset, low_next;
    logic          mem_we;
    logic [VW-1:0] mem_rdata;

    assign is_cmd   = wr_en && !wr_is_data;
    assign do_reset = is_cmd && (wr_byte == 8'h00);
    assign line     = wr_byte[IW-1:0];
    assign pending  = s_q.irr & ~s_q.imr;
    assign start    = s_q.mode.rotate ? s_q.last + 1'b1 : '0;
    assign rd_addr  = s_q.mode.common ? '0 : win;
    assign mem_we   = wr_en && wr_is_data && (s_q.sel == SEL_VEC);

    // polarity for next cycle, kept apart from s_d so the edge unit sees no loop
    always_comb begin
        low_next = s_q.mode.active_low;
        if (do_reset)
            low_next = 1'b0;
        else if (is_cmd && wr_byte[7:5] == 3'b100)
            low_next = wr_byte[3];
    end

    vpic_edge #(.N(N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_in),
        .low_q (s_q.mode.active_low),
        .low_d (low_next),
        .rise  (rise)
    );

    vpic_resolver #(.N(N), .IW(IW)) u_res (
        .pend  (pending),
        .start (start),
        .found (found),
        .win   (win)
    );

    vpic_vecmem #(.DEPTH(N), .W(VW), .AW(IW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (s_q.vptr),
        .wdata (wr_byte[VW-1:0]),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    always_comb begin
        s_d      = s_q;
        s_d.vval = 1'b0;
        if (do_reset) begin
            s_d.irr  = '0;
            s_d.imr  = '1;
            s_d.isr  = '0;
            s_d.acr  = '0;
            s_d.mode = '0;
            s_d.en   = 1'b0;
            s_d.sel  = SEL_NONE;
            s_d.vptr = '0;
            s_d.last = '1;
        end else begin
            if (is_cmd) begin
                case (wr_byte[7:3])
                    OP_SET_IMR: s_d.imr[line] = 1'b1;
                    OP_CLR_IMR: s_d.imr[line] = 1'b0;
                    OP_CLR_IRR: s_d.irr[line] = 1'b0;
                    OP_SET_IRR: s_d.irr[line] = 1'b1;
                    OP_CLR_ISR: s_d.isr[line] = 1'b0;
                    OP_ENABLE:  s_d.en        = wr_byte[0];
                    OP_SEL_ACR: s_d.sel       = SEL_ACR;
                    OP_SEL_VEC: begin
                        s_d.sel  = SEL_VEC;
                        s_d.vptr = line;
                    end
                    5'b10000, 5'b10001, 5'b10010, 5'b10011:
                        s_d.mode = mode_t'(wr_byte[4:0]);
                    default: ;
                endcase
            end else if (wr_en && wr_is_data) begin
                if (s_q.sel == SEL_ACR)
                    s_d.acr = wr_byte[N-1:0];
                else if (s_q.sel == SEL_VEC)
                    s_d.vptr = s_q.vptr + 1'b1;
            end
            if (ack_i && found) begin
                s_d.irr[win] = 1'b0;
                if (!s_q.acr[win]) s_d.isr[win] = 1'b1;
                s_d.last = win;
                s_d.vec  = mem_rdata;
                s_d.vval = 1'b1;
            end
        end
        // a fresh edge wins over any clear in the same cycle
        s_d.irr = s_d.irr | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.imr  <= '1;
            s_q.sel  <= SEL_NONE;
            s_q.last <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o       = s_q.mode.arm && s_q.en && !s_q.mode.polled && (|pending);
    assign status_o    = {|pending, irq_o, s_q.en, s_q.mode};
    assign vec_o       = s_q.vec;
    assign vec_valid_o = s_q.vval;

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data_o = s_q.irr;
            2'd1:    rd_data_o = s_q.imr;
            2'd2:    rd_data_o = s_q.isr;
            default: rd_data_o = s_q.acr;
        endcase
    end

    // R10: polled mode never drives the interrupt line
    p_polled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mode.polled |-> !irq_o);

    // R4: interrupt only with arm, enable and an unmasked request
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (s_q.mode.arm && s_q.en && (|(s_q.irr & ~s_q.imr))));

    // R2: every detected edge is latched into the request register
    p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((s_q.irr & $past(rise)) == $past(rise)));

    // R7: an acknowledge with a winner yields a vector next cycle
    p_ack_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && found && !do_reset) |=> vec_valid_o);

    // R5: the resolver only grants a pending, unmasked line
    p_grant_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> pending[win]);
endmodule

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = 8'h00;
    logic       wr_en = 1'b0;
    logic       wr_is_data = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       ack_i = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data_o, status_o, vec_o;
    logic       irq_o, vec_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vpic_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en),
        .wr_is_data(wr_is_data), .wr_byte(wr_byte), .ack_i(ack_i),
        .rd_sel(rd_sel), .rd_data_o(rd_data_o), .status_o(status_o),
        .irq_o(irq_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wcmd(input logic [7:0] b);
        wr_en = 1'b1; wr_is_data = 1'b0; wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wdat(input logic [7:0] b);
        wr_en = 1'b1; wr_is_data = 1'b1; wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0; wr_is_data = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data_o;
    endtask

    // ack pulse; returns valid flag and vector seen the cycle after
    task automatic do_ack(output logic vld, output logic [7:0] v);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        vld = vec_valid_o;
        v = vec_o;
    endtask

    task automatic unmask_all;
        for (int i = 0; i < 8; i++) wcmd(8'h28 + 8'(i));
    endtask

    task automatic setup(input logic [7:0] mode);
        wcmd(8'h00);
        wcmd(8'h80 | mode);
        wcmd(8'hA1);
        unmask_all();
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); chk("R1 irr", v, 8'h00);
        rd(2'd1, v); chk("R1 imr", v, 8'hFF);
        rd(2'd2, v); chk("R1 isr", v, 8'h00);
        rd(2'd3, v); chk("R1 acr", v, 8'h00);
        chk("R1 status", status_o, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_fixed;
        logic vld; logic [7:0] v;
        wcmd(8'h90); wcmd(8'hA1);               // R12 arm, fixed, individual
        unmask_all();
        wcmd(8'hE0);                             // R9 vector entries from 0
        for (int i = 0; i < 8; i++) wdat(8'h40 + 8'(i));
        req_in = 8'h24;
        @(negedge clk);
        rd(2'd0, v); chk("R2 edge latch", v, 8'h24);
        chk("R4 irq on", {7'd0, irq_o}, 8'h01);
        do_ack(vld, v);
        chk("R7 valid", {7'd0, vld}, 8'h01);
        chk("R5 fixed winner vec", v, 8'h42);
        rd(2'd0, v); chk("R7 irr after ack", v, 8'h20);
        rd(2'd2, v); chk("R7 isr after ack", v, 8'h04);
        do_ack(vld, v); chk("R5 second vec", v, 8'h45);
        chk("R4 irq off", {7'd0, irq_o}, 8'h00);
        do_ack(vld, v); chk("R7 no winner no valid", {7'd0, vld}, 8'h00);
        wcmd(8'h1B);                             // R3 mask line 3
        req_in = 8'h2C;
        @(negedge clk);
        rd(2'd0, v); chk("R3 masked req latched", v, 8'h08);
        chk("R4 masked no irq", {7'd0, irq_o}, 8'h00);
        wcmd(8'h2B);
        chk("R3 unmask raises irq", {7'd0, irq_o}, 8'h01);
        wcmd(8'h4B);
        rd(2'd0, v); chk("R3 clear irr", v, 8'h00);
        wcmd(8'h5D); wcmd(8'h4D);                // set then clear line 5, held high
        @(negedge clk);
        rd(2'd0, v); chk("R2 held level no relatch", v, 8'h00);
        req_in = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_rotate;
        logic vld; logic [7:0] v;
        setup(8'h11);
        wcmd(8'h59); wcmd(8'h5B); wcmd(8'h5E);   // R3 set lines 1,3,6
        rd(2'd0, v); chk("R3 set irr", v, 8'h4A);
        do_ack(vld, v); chk("R6 first from line 0", v, 8'h41);
        wcmd(8'h58);
        do_ack(vld, v); chk("R6 line 3 beats 0", v, 8'h43);
        do_ack(vld, v); chk("R6 then line 6", v, 8'h46);
        do_ack(vld, v); chk("R6 wrap to line 0", v, 8'h40);
    endtask

    task automatic t_acr;
        logic vld; logic [7:0] v;
        setup(8'h10);
        wcmd(8'hC0); wdat(8'h10);
        rd(2'd3, v); chk("R9 acr load", v, 8'h10);
        wcmd(8'h5C); wcmd(8'h5D);
        do_ack(vld, v); chk("R7 acr line vec", v, 8'h44);
        rd(2'd2, v); chk("R7 acr keeps isr clear", v, 8'h00);
        rd(2'd0, v); chk("R7 acr irr cleared", v, 8'h20);
        do_ack(vld, v);
        rd(2'd2, v); chk("R7 isr set", v, 8'h20);
        wcmd(8'h75);
        rd(2'd2, v); chk("R11 clear isr", v, 8'h00);
    endtask

    task automatic t_data_ignored;
        logic vld; logic [7:0] v;
        wcmd(8'h00);
        wdat(8'h99);                             // nothing preselected
        rd(2'd3, v); chk("R9 acr untouched", v, 8'h00);
        rd(2'd1, v); chk("R1 reset cmd imr", v, 8'hFF);
        wcmd(8'h90); wcmd(8'hA1); unmask_all();
        wcmd(8'h5F);
        do_ack(vld, v); chk("R9 vector untouched", v, 8'h47);
        wcmd(8'hE6); wdat(8'h77); wdat(8'h88);
        wcmd(8'h5F);
        do_ack(vld, v); chk("R9 auto increment", v, 8'h88);
        wcmd(8'h5E);
        do_ack(vld, v); chk("R9 first data entry", v, 8'h77);
    endtask

    task automatic t_common;
        logic vld; logic [7:0] v;
        setup(8'h12);
        wcmd(8'h5A);
        do_ack(vld, v); chk("R8 common vector", v, 8'h40);
    endtask

    task automatic t_polled;
        setup(8'h14);
        wcmd(8'h59);
        chk("R10 polled no irq", {7'd0, irq_o}, 8'h00);
        chk("R10 status flag", status_o, 8'hB4);
        wcmd(8'h80);
        chk("R4 disarmed no irq", {7'd0, irq_o}, 8'h00);
        wcmd(8'h90);
        chk("R12 arm raises irq", {7'd0, irq_o}, 8'h01);
        wcmd(8'hA0);
        chk("R12 enable off", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_low;
        logic [7:0] v;
        setup(8'h18);                            // inputs sit at 0 = active
        rd(2'd0, v); chk("R2 polarity load silent", v, 8'h00);
        req_in = 8'hFF;
        @(negedge clk);
        rd(2'd0, v); chk("R2 rising ignored in low mode", v, 8'h00);
        req_in = 8'hFE;
        @(negedge clk);
        rd(2'd0, v); chk("R2 falling edge latched", v, 8'h01);
        wcmd(8'h00);
        req_in = 8'h00;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_rotate();
        t_acr();
        t_data_ignored();
        t_common();
        t_polled();
        t_low();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule